// File: doc/BRIEF.md
# Fast RC Clock Prescaler

This block divides a fast on-chip RC reference clock by a ratio picked with a 3-bit code. The result is the clock that feeds input zero of a system clock multiplexer. For every ratio of two or more the block produces a registered divided clock with an even duty cycle. Code zero bypasses the divider, so the reference clock comes straight through. A single-cycle tick marks the last reference cycle of each divided period. Logic that runs on the reference clock can use the tick as a clock enable.

The ratio doubles with each code up to 64. The top code then jumps to 256 instead of 128. The select input is a plain signal, not a register access. The block samples it only when a divided period ends. A change made in the middle of a period therefore never shortens a high or low phase. Reset is synchronous and active high. It empties the counter and returns the block to the bypass ratio.

Top module: `fdiv_prescaler`

## Requirements
- R1: Code 3'b000 selects divide-by-1. `div_clk_o` then follows `clk` and `tick_o` is high on every cycle. This is the state after reset.
- R2: Codes 3'b001, 3'b010, 3'b011 and 3'b100 give divided periods of 2, 4, 8 and 16 reference cycles.
- R3: Codes 3'b101 and 3'b110 give divided periods of 32 and 64 reference cycles.
- R4: Code 3'b111 gives a divided period of 256 reference cycles (2 to the power TOP_SHIFT), not 128.
- R5: `sel_i` is sampled only in the last cycle of a divided period. A change made earlier leaves the running period at its old ratio and length.
- R6: For a ratio N of 2 or more, `div_clk_o` is high for the first N/2 reference cycles of each period and low for the remaining N/2.
- R7: `tick_o` is high for exactly one reference cycle per divided period, namely the last cycle of that period.
- R8: While `rst` is high at a rising edge of `clk`, the counter clears and divide-by-1 is forced whatever `sel_i` holds. After that edge, `tick_o` is high and `div_clk_o` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast RC reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Divide ratio code |
| div_clk_o | output | 1 | Divided clock (the reference clock itself for code 000) |
| tick_o | output | 1 | One-cycle pulse in the last reference cycle of each divided period |

## Verification
The bench builds the block with the default TOP_SHIFT of 8. This makes the 256-cycle top ratio reachable, and the jump from 64 to 256 can be measured directly. It does not follow the power-of-two pattern, which would give 128. All eight codes are applied in turn, along with transitions between widely separated ratios in both directions. The remaining cases are a select change in the middle of a long period, and a reset that arrives while the longest ratio is running.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int SEL_W = 3;

    typedef logic [SEL_W-1:0] fdiv_sel_t;

    // Codes with special meaning; the others select 2**code.
    localparam fdiv_sel_t SEL_BYPASS = 3'd0;
    localparam fdiv_sel_t SEL_TOP    = 3'd7;

    // Division ratio for a code; the top code jumps to 2**top_shift.
    function automatic int unsigned ratio_of(fdiv_sel_t s, int unsigned top_shift);
        if (s == SEL_TOP)
            return 32'd1 << top_shift;
        return 32'd1 << s;
    endfunction

    // Last counter value of a period (ratio - 1).
    function automatic int unsigned last_of(fdiv_sel_t s, int unsigned top_shift);
        return ratio_of(s, top_shift) - 32'd1;
    endfunction

    // Number of high cycles of the divided clock (ratio / 2).
    function automatic int unsigned half_of(fdiv_sel_t s, int unsigned top_shift);
        return ratio_of(s, top_shift) >> 1;
    endfunction

endpackage

// File: rtl/fdiv_sel_hold.sv
module fdiv_sel_hold
    import fdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wrap,
    input  fdiv_sel_t sel_in,
    output fdiv_sel_t sel_q,
    output fdiv_sel_t sel_nxt
);

    // A new code is accepted only on the last cycle of a period.
    always_comb begin
        sel_nxt = wrap ? sel_in : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= SEL_BYPASS;
        else
            sel_q <= sel_nxt;
    end

    assert_sel_held_R5: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(sel_q));

endmodule

// File: rtl/fdiv_count.sv
module fdiv_count
    import fdiv_pkg::*;
#(
    parameter int TOP_SHIFT = 8,
    localparam int CNT_W    = TOP_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  fdiv_sel_t        sel_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);

    logic [CNT_W-1:0] last;

    always_comb begin
        last    = CNT_W'(last_of(sel_q, TOP_SHIFT));
        wrap    = (cnt_q == last);
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= last_of(sel_q, TOP_SHIFT));

endmodule

// File: rtl/fdiv_phase.sv
module fdiv_phase
    import fdiv_pkg::*;
#(
    parameter int TOP_SHIFT = 8,
    localparam int CNT_W    = TOP_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  fdiv_sel_t        sel_nxt,
    output logic             div_q,
    output logic             tick_q
);

    logic high_nxt;
    logic tick_nxt;

    // Both outputs are registered images of the next counter state.
    always_comb begin
        high_nxt = 32'(cnt_nxt) < half_of(sel_nxt, TOP_SHIFT);
        tick_nxt = 32'(cnt_nxt) == last_of(sel_nxt, TOP_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= 1'b0;
            tick_q <= 1'b1;
        end else begin
            div_q  <= high_nxt;
            tick_q <= tick_nxt;
        end
    end

    // A high phase may only begin right after a period has closed.
    assert_rise_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> $past(tick_q));

endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler
    import fdiv_pkg::*;
#(
    parameter int TOP_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel_i,
    output logic       div_clk_o,
    output logic       tick_o
);

    localparam int CNT_W = TOP_SHIFT;

    fdiv_sel_t        sel_q;
    fdiv_sel_t        sel_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             div_q;
    logic             tick_q;

    fdiv_sel_hold u_sel (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .sel_in  (fdiv_sel_t'(sel_i)),
        .sel_q   (sel_q),
        .sel_nxt (sel_nxt)
    );

    fdiv_count #(.TOP_SHIFT(TOP_SHIFT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .sel_q   (sel_q),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    fdiv_phase #(.TOP_SHIFT(TOP_SHIFT)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .sel_nxt (sel_nxt),
        .div_q   (div_q),
        .tick_q  (tick_q)
    );

    always_comb begin
        div_clk_o = (sel_q == SEL_BYPASS) ? clk : div_q;
        tick_o    = tick_q;
    end

    assert_tick_at_last_R7: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (32'(cnt_q) == last_of(sel_q, TOP_SHIFT)));

    assert_bypass_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SEL_BYPASS) |-> tick_o);

    assert_reset_div1_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tick_o && cnt_q == '0));

endmodule

// File: tb/fdiv_prescaler_test.sv
`timescale 1ns/1ps
module fdiv_prescaler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd3;
    logic       div_clk;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int n_cyc;
    int n_high;

    always #5 clk = ~clk;

    fdiv_prescaler #(.TOP_SHIFT(8)) uut (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel),
        .div_clk_o (div_clk),
        .tick_o    (tick)
    );

    // {code, expected period}
    localparam int NVEC = 13;
    localparam logic [11:0] VEC [NVEC] = '{
        {3'd0, 9'd1},  {3'd1, 9'd2},  {3'd2, 9'd4},  {3'd3, 9'd8},
        {3'd4, 9'd16}, {3'd5, 9'd32}, {3'd6, 9'd64}, {3'd7, 9'd256},
        {3'd0, 9'd1},  {3'd6, 9'd64}, {3'd2, 9'd4},  {3'd7, 9'd256},
        {3'd1, 9'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count cycles (sampled at negedge) up to and including the next tick.
    task automatic run_period();
        do begin
            @(negedge clk);
            n_cyc++;
            if (div_clk) n_high++;
        end while (!tick && n_cyc < 1000);
    endtask

    task automatic measure(input string req, input int ratio);
        n_cyc = 0;
        n_high = 0;
        run_period();
        check({req, " period"}, n_cyc, ratio);
        check({req, " high cycles (R6)"}, n_high, ratio / 2);
    endtask

    function automatic string req_of(input int code);
        if (code == 0) return "R1";
        if (code <= 4) return "R2";
        if (code <= 6) return "R3";
        return "R4";
    endfunction

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset forces divide-by-1 even with a nonzero code applied
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset tick", int'(tick), 1);
        check("R8 reset div low at negedge", int'(div_clk), 0);
        rst = 1'b0;
        measure("R2 first period after reset", 8);

        for (int i = 0; i < NVEC; i++) begin
            sel = VEC[i][11:9];
            measure(req_of(int'(VEC[i][11:9])), int'(VEC[i][8:0]));
        end

        // R1: bypass passes the reference clock through
        sel = 3'd0;
        measure("R1", 1);
        @(posedge clk);
        #2;
        check("R1 div follows clk high", int'(div_clk), 1);
        check("R1 tick each cycle", int'(tick), 1);
        @(negedge clk);

        // R5: change in mid-period does not cut the running period
        sel = 3'd5;
        measure("R3 before mid change", 32);
        n_cyc = 0;
        n_high = 0;
        repeat (3) begin
            @(negedge clk);
            n_cyc++;
            if (div_clk) n_high++;
        end
        sel = 3'd1;
        run_period();
        check("R5 period kept at old ratio", n_cyc, 32);
        check("R5 high phase kept", n_high, 16);
        measure("R5 new ratio after boundary", 2);

        // R7: tick is a single cycle in a long period
        sel = 3'd4;
        measure("R7 setup", 16);
        @(negedge clk);
        check("R7 tick low after period start", int'(tick), 0);

        // R8: reset during the longest ratio
        sel = 3'd7;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 tick forced", int'(tick), 1);
        check("R8 div low at negedge", int'(div_clk), 0);
        @(posedge clk);
        #2;
        check("R8 div follows clk", int'(div_clk), 1);
        @(negedge clk);
        sel = 3'd0;
        rst = 1'b0;
        measure("R8 divide-by-1 after reset", 1);
        measure("R8 divide-by-1 after reset", 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule